// File: doc/BRIEF.md
# Dual-Bank Glitchless Divider Reconfiguration Controller

This controller keeps two full clock-divider settings, bank 0 and bank 1. Each bank holds a source select, a pre-divide code and an M/N counter pair with its counter mode. One select bit decides which bank feeds the divider datapath, and the fields of that bank appear on the readback outputs. The datapath itself lies outside this block.

A reconfiguration request carries a complete new setting. When the divided clock is running (`out_en` high), the controller writes the setting into the idle bank. It then flips the select bit, so the running clock moves from one finished setting to the other in a single step. When the clock is stopped, it rewrites the active bank in place and leaves the select bit alone.

Writes follow a fixed order of one step per cycle:
1. Hold the target bank's M/N counter in reset.
2. Write M, then N, then the counter mode.
3. Release the reset.
4. Write the pre-divide and source fields.

Each bank has a table of permitted sources. A request that breaks this table, or that arrives while a sequence is running, is dropped and reported on `req_err`.

Top module: `dual_bank_divctl`

## Requirements
- R1: After reset `bank_sel`, `busy`, `req_err` and `mn_rst` are 0, and every readback field is 0.
- R2: The target bank is fixed when a request is accepted. It is the bank other than `bank_sel` when `out_en` is 1, and bank `bank_sel` when `out_en` is 0. `busy` rises only after a cycle with `req_valid` high.
- R3: Let edge 0 be the clock edge that accepts the request. Then:
  - `mn_rst[target]` is 1 after edges 1 to 4 and cleared after edge 5.
  - M is written at edge 2, N at edge 3 and the mode at edge 4.
  - Pre-divide and source are written together at edge 6.
  - At most one `mn_rst` bit is set, and only while `busy` is high.
- R4: If `out_en` was 1 at acceptance, `bank_sel` toggles at edge 7 and `busy` is high after edges 0 to 6. Otherwise `bank_sel` never changes and `busy` is high after edges 0 to 5. `bank_sel` changes only in the cycle where `busy` falls.
- R5: During a reconfiguration with the clock running, every readback output keeps the old active values until the select toggle.
- R6: A request with N = 0 stores M = 0 and N = 0 and mode code 2'b00 (bypass). A request with N ≠ 0 stores the M and N given and mode code 2'b10 (dual-edge counting).
- R7: With SHARED_MODE = 1 both banks use one mode register. `cur_mode` then shows the new mode after edge 4, whichever bank is the target.
- R8: A source is permitted in a bank when bit `req_src` of that bank's mask (BANK0_SRC_OK or BANK1_SRC_OK) is 1. A request whose source is not permitted in its target bank is handled as follows:
  - `req_err` is high for exactly the one cycle after the request.
  - `busy` stays 0.
  - No field changes.
- R9: A request made while `busy` is high is ignored. `req_err` is high in the following cycle, and the running sequence completes with its own values.
- R10: `cur_src`, `cur_pdiv`, `cur_m`, `cur_n` and `cur_mode` always show the bank that `bank_sel` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_en | input | 1 | Divided clock currently running |
| req_valid | input | 1 | Reconfiguration request strobe |
| req_src | input | SRC_W | Requested source index |
| req_pdiv | input | PDIV_W | Requested pre-divide code |
| req_m | input | MN_W | Requested M value |
| req_n | input | MN_W | Requested N value, 0 for bypass |
| busy | output | 1 | Sequence in progress |
| req_err | output | 1 | One-cycle pulse for a rejected or ignored request |
| bank_sel | output | 1 | Active bank, 1 selects bank 1 |
| mn_rst | output | 2 | Per-bank M/N counter reset |
| cur_src | output | SRC_W | Active bank source select |
| cur_pdiv | output | PDIV_W | Active bank pre-divide code |
| cur_m | output | MN_W | Active bank M value |
| cur_n | output | MN_W | Active bank N value |
| cur_mode | output | 2 | Active counter mode code |

## Verification
The bench uses two instances that share all other parameters: SRC_W = 3 and 8-bit M/N fields. Instance u0 keeps a counter mode per bank and u1 has SHARED_MODE = 1. The two banks get different source masks, so the run covers every source against both permission tables, with the clock both running and stopped. Together this reaches each accepted and rejected path, every step of the write sequence cycle by cycle, and the bank flips that alternate the target.

// File: rtl/dual_bank_divctl.sv
module dual_bank_divctl #(
  parameter int SRC_W = 3,
  parameter int PDIV_W = 4,
  parameter int MN_W = 8,
  parameter bit SHARED_MODE = 1'b0,
  parameter logic [(1<<SRC_W)-1:0] BANK0_SRC_OK = '1,
  parameter logic [(1<<SRC_W)-1:0] BANK1_SRC_OK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PDIV_W-1:0] req_pdiv,
  input  logic [MN_W-1:0]   req_m,
  input  logic [MN_W-1:0]   req_n,
  output logic              busy,
  output logic              req_err,
  output logic              bank_sel,
  output logic [1:0]        mn_rst,
  output logic [SRC_W-1:0]  cur_src,
  output logic [PDIV_W-1:0] cur_pdiv,
  output logic [MN_W-1:0]   cur_m,
  output logic [MN_W-1:0]   cur_n,
  output logic [1:0]        cur_mode
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_M, ST_N, ST_MODE, ST_REL, ST_PS, ST_SWAP
  } step_t;

  step_t st;
  logic tgt, swap_pend;
  logic [SRC_W-1:0]  l_src;
  logic [PDIV_W-1:0] l_pd;
  logic [MN_W-1:0]   l_m, l_n;

  logic [SRC_W-1:0]  src_r [2];
  logic [PDIV_W-1:0] pd_r  [2];
  logic [MN_W-1:0]   m_r   [2];
  logic [MN_W-1:0]   n_r   [2];

  wire nxt_tgt = out_en ? ~bank_sel : bank_sel;
  wire src_ok  = nxt_tgt ? BANK1_SRC_OK[req_src] : BANK0_SRC_OK[req_src];
  wire accept  = req_valid && (st == ST_IDLE) && src_ok;
  wire [1:0] mode_code = (l_n != '0) ? 2'b10 : 2'b00;

  assign busy     = (st != ST_IDLE);
  assign cur_src  = src_r[bank_sel];
  assign cur_pdiv = pd_r[bank_sel];
  assign cur_m    = m_r[bank_sel];
  assign cur_n    = n_r[bank_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tgt       <= 1'b0;
      swap_pend <= 1'b0;
      l_src     <= '0;
      l_pd      <= '0;
      l_m       <= '0;
      l_n       <= '0;
      bank_sel  <= 1'b0;
      mn_rst    <= 2'b00;
      req_err   <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        src_r[b] <= '0;
        pd_r[b]  <= '0;
        m_r[b]   <= '0;
        n_r[b]   <= '0;
      end
    end else begin
      req_err <= req_valid && !accept;
      case (st)
        ST_IDLE: if (accept) begin
          tgt       <= nxt_tgt;
          swap_pend <= out_en;
          l_src     <= req_src;
          l_pd      <= req_pdiv;
          l_m       <= req_m;
          l_n       <= req_n;
          st        <= ST_RST;
        end
        ST_RST: begin
          mn_rst[tgt] <= 1'b1;
          st          <= ST_M;
        end
        ST_M: begin
          m_r[tgt] <= (l_n != '0) ? l_m : '0;
          st       <= ST_N;
        end
        ST_N: begin
          n_r[tgt] <= l_n;
          st       <= ST_MODE;
        end
        ST_MODE: st <= ST_REL;
        ST_REL: begin
          mn_rst[tgt] <= 1'b0;
          st          <= ST_PS;
        end
        ST_PS: begin
          pd_r[tgt]  <= l_pd;
          src_r[tgt] <= l_src;
          st         <= swap_pend ? ST_SWAP : ST_IDLE;
        end
        default: begin
          bank_sel <= ~bank_sel;
          st       <= ST_IDLE;
        end
      endcase
    end
  end

  generate
    if (SHARED_MODE) begin : g_shared_mode
      logic [1:0] mode_sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_sh <= 2'b00;
        else if (st == ST_MODE) mode_sh <= mode_code;
      end
      assign cur_mode = mode_sh;
    end else begin : g_bank_mode
      logic [1:0] mode_b [2];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_b[0] <= 2'b00;
          mode_b[1] <= 2'b00;
        end else if (st == ST_MODE) begin
          mode_b[tgt] <= mode_code;
        end
      end
      assign cur_mode = mode_b[bank_sel];
    end
  endgenerate

endmodule

// File: rtl/dual_bank_divctl_chk.sv
module dual_bank_divctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       req_err,
  input logic       bank_sel,
  input logic [1:0] mn_rst
);

  assert_err_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> req_err);

  assert_sel_moves_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_sel) |-> ($past(busy) && !busy));

  assert_rst_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mn_rst));

  assert_rst_inside_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mn_rst != 2'b00) |-> busy);

  assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

endmodule

bind dual_bank_divctl dual_bank_divctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .req_err(req_err), .bank_sel(bank_sel), .mn_rst(mn_rst)
);

// File: tb/sim_dual_bank_divctl.sv
module sim_dual_bank_divctl;
  localparam int SW = 3, PW = 4, MW = 8;
  localparam logic [7:0] OK0 = 8'b0110_1101;
  localparam logic [7:0] OK1 = 8'b1011_0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic out_en = 1'b0, req_valid = 1'b0;
  logic [SW-1:0] req_src = '0;
  logic [PW-1:0] req_pdiv = '0;
  logic [MW-1:0] req_m = '0, req_n = '0;

  logic busy, req_err, bank_sel;
  logic [1:0] mn_rst, cur_mode;
  logic [SW-1:0] cur_src;
  logic [PW-1:0] cur_pdiv;
  logic [MW-1:0] cur_m, cur_n;

  logic b1, e1, s1;
  logic [1:0] r1, md1;
  logic [SW-1:0] cs1;
  logic [PW-1:0] cp1;
  logic [MW-1:0] cm1, cn1;

  always #4 clk = ~clk;

  dual_bank_divctl #(.SRC_W(SW), .PDIV_W(PW), .MN_W(MW), .SHARED_MODE(1'b0),
    .BANK0_SRC_OK(OK0), .BANK1_SRC_OK(OK1)) u0 (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .req_valid(req_valid),
    .req_src(req_src), .req_pdiv(req_pdiv), .req_m(req_m), .req_n(req_n),
    .busy(busy), .req_err(req_err), .bank_sel(bank_sel), .mn_rst(mn_rst),
    .cur_src(cur_src), .cur_pdiv(cur_pdiv), .cur_m(cur_m), .cur_n(cur_n),
    .cur_mode(cur_mode));

  dual_bank_divctl #(.SRC_W(SW), .PDIV_W(PW), .MN_W(MW), .SHARED_MODE(1'b1),
    .BANK0_SRC_OK(OK0), .BANK1_SRC_OK(OK1)) u1 (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .req_valid(req_valid),
    .req_src(req_src), .req_pdiv(req_pdiv), .req_m(req_m), .req_n(req_n),
    .busy(b1), .req_err(e1), .bank_sel(s1), .mn_rst(r1),
    .cur_src(cs1), .cur_pdiv(cp1), .cur_m(cm1), .cur_n(cn1),
    .cur_mode(md1));

  int checks = 0, failures = 0, cyc = 0;
  int msrc[2], mpd[2], mm[2], mn[2], mmode[2];
  int msh = 0, msel = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_active(input string tag);
    chk({tag, " src"}, cur_src, msrc[msel]);
    chk({tag, " pdiv"}, cur_pdiv, mpd[msel]);
    chk({tag, " m"}, cur_m, mm[msel]);
    chk({tag, " n"}, cur_n, mn[msel]);
    chk({tag, " mode"}, cur_mode, mmode[msel]);
    chk({tag, " sel"}, bank_sel, msel);
    chk({tag, " shared mode R7"}, md1, msh);
  endtask

  task automatic run_req(input int en, input int s, input int pd, input int m, input int n);
    int tgt, ok, nm, nmode;
    int o_src, o_pd, o_m, o_n, o_mode;
    @(negedge clk);
    out_en = en[0]; req_valid = 1'b1;
    req_src = s[SW-1:0]; req_pdiv = pd[PW-1:0]; req_m = m[MW-1:0]; req_n = n[MW-1:0];
    tgt = en ? 1 - msel : msel;
    ok = tgt ? OK1[s] : OK0[s];
    o_src = msrc[msel]; o_pd = mpd[msel]; o_m = mm[msel]; o_n = mn[msel]; o_mode = mmode[msel];
    @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      chk("R8 err pulse", req_err, 1);
      chk("R8 busy low", busy, 0);
      repeat (7) @(negedge clk);
      chk("R8 err single", req_err, 0);
      chk_active("R8 unchanged");
      return;
    end
    chk("R2 no err", req_err, 0);
    chk("R4 busy after accept", busy, 1);
    nm = (n != 0) ? m : 0;
    nmode = (n != 0) ? 2 : 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k <= 4) chk("R3 reset held", mn_rst[tgt], 1);
      if (k == 5) chk("R3 reset released", mn_rst, 0);
      if (k == 4) chk("R7 shared mode early", md1, nmode);
      if (en) begin
        if (k <= 6) begin
          chk("R4 busy", busy, 1);
          chk("R5 src hold", cur_src, o_src);
          chk("R5 pdiv hold", cur_pdiv, o_pd);
          chk("R5 m hold", cur_m, o_m);
          chk("R5 n hold", cur_n, o_n);
          chk("R5 mode hold", cur_mode, o_mode);
        end else begin
          chk("R4 busy end", busy, 0);
          chk("R4 toggled", bank_sel, tgt);
        end
      end else begin
        if (k == 2) chk("R3 m at edge2", cur_m, nm);
        if (k == 3) chk("R3 n at edge3", cur_n, n);
        if (k == 4) chk("R3 mode at edge4", cur_mode, nmode);
        if (k == 5) chk("R3 src not yet", cur_src, o_src);
        if (k == 6) begin
          chk("R4 busy end", busy, 0);
          chk("R2 in place", bank_sel, msel);
          break;
        end
      end
    end
    msrc[tgt] = s; mpd[tgt] = pd; mm[tgt] = nm; mn[tgt] = n;
    mmode[tgt] = nmode; msh = nmode;
    if (en) msel = tgt;
    chk_active("R10 R6 final");
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      msrc[b] = 0; mpd[b] = 0; mm[b] = 0; mn[b] = 0; mmode[b] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 sel", bank_sel, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", req_err, 0);
    chk("R1 rst", mn_rst, 0);
    chk_active("R1 fields");
    rst_n = 1'b1;
    @(negedge clk);
    for (int en = 0; en < 2; en++)
      for (int s = 0; s < 8; s++)
        for (int v = 0; v < 3; v++)
          run_req(en, s, (s + v + en) % 16, s * 3 + v + 1, (v == 0) ? 0 : s * 5 + v * 7);
    run_req(1, 0, 9, 4, 9);
    run_req(1, 0, 2, 7, 0);

    begin
      int tgt, fm;
      @(negedge clk);
      out_en = 1'b1; req_valid = 1'b1;
      req_src = 3'd0; req_pdiv = 4'd5; req_m = 8'd3; req_n = 8'd11;
      tgt = 1 - msel;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_src = 3'd2; req_pdiv = 4'd1; req_m = 8'd9; req_n = 8'd0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 err pulse", req_err, 1);
      fm = 0;
      for (int w = 0; w < 20 && busy; w++) @(negedge clk);
      chk("R9 busy done", busy, 0);
      msrc[tgt] = 0; mpd[tgt] = 5; mm[tgt] = 3; mn[tgt] = 11; mmode[tgt] = 2;
      msh = 2; msel = tgt;
      chk_active("R9 first wins");
      @(negedge clk);
      chk("R9 no restart", busy, fm);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule